// File: doc/BRIEF.md
# Periodic Countdown Interrupt Timer

This block raises an interrupt at a fixed interval chosen by software. It is meant to sit beside the clock-calendar logic of a real-time clock. A 24-bit preset sets the interval. The time base is one of four single-cycle tick strobes that an external prescaler supplies: 4096 Hz, 64 Hz, a free-running one-second tick, and a one-minute tick aligned to the minute rollover. Each selected tick steps a down counter. When the counter runs out, it reloads from the preset in the same cycle and posts a sticky event flag.

Software reaches the block through a byte-wide register port with an address, write data, a write strobe and combinational read data. If interrupts are enabled, each event pulls the active-low interrupt pin low. The pin releases by itself after a width that depends on the source. The flag stays set until software clears it. The live count can be read through three read-only monitor bytes. The preset bytes always behave as ordinary storage, so software can use them as scratch bytes while the timer is off.

Top module: `cyc_timer`

## Requirements
- R1: After reset, every register reads 0 except the mode byte. The mode byte at 0x0D reads 0x01: source 64 Hz, counting off. The interrupt pin is high.
- R2: The preset bytes can be written and read back: bits 7:0 at 0x0B, bits 15:8 at 0x0C, bits 23:16 at 0x1F. The monitor bytes hold the live count: bits 7:0 at 0x1C, bits 15:8 at 0x1D, bits 23:16 at 0x1E. Writes to the monitor bytes have no effect.
- R3: Writing bit 4 of the mode byte (0x0D) from 0 to 1 starts counting. The first selected tick after that loads the preset. Each later selected tick decrements the count. The count is not touched before the first tick.
- R4: A tick that finds the count at 1 reloads the preset in that same cycle and sets the event flag, so a loaded count never reads as 0. The event flag is bit 4 of the byte at 0x0E.
- R5: Bits 1:0 of the mode byte select the source: 00 = 4096 Hz, 01 = 64 Hz, 10 = one-second, 11 = one-minute. Ticks from sources that are not selected leave the count unchanged.
- R6: Writing 0 to the flag bit clears it. Writing 1 leaves it unchanged. Hardware never clears it.
- R7: The interrupt pin goes low on an event only when bit 4 of the control byte (0x0F) is 1. Otherwise it stays high.
- R8: A low pulse started with the 4096 Hz source ends on the next 4096 Hz tick. With any other source it ends on the 32nd 4096 Hz tick after the event.
- R9: While all 24 preset bits are 0, the count holds and no events occur.
- R10: While bit 0 of the control byte (the hold bit) is 1, or bit 4 of the mode byte is 0, the count holds its value.
- R11: Writing the flag bit to 0, or writing bit 4 of the control byte to 0, releases a low interrupt pin in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_4k | input | 1 | 4096 Hz single-cycle strobe |
| tick_64 | input | 1 | 64 Hz single-cycle strobe |
| tick_sec | input | 1 | Free-running one-second strobe |
| tick_min | input | 1 | One-minute strobe, aligned to minute rollover |
| reg_addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for reg_addr (combinational) |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
The checks assume that each tick strobe is high for at most one cycle at a time. They also assume that a write lasts exactly one cycle and is not repeated while its effect settles. The stimulus drives every tick and write as an isolated one-cycle pulse with an idle cycle after it. Reads are made in cycles that carry neither a tick nor a write. The properties about holding and reloading also take it for granted that nothing but the selected tick moves the count. The bench keeps this true by pulsing non-selected sources only to show that they are ignored.

// File: rtl/ct_pkg.sv
`timescale 1ns/1ps
package ct_pkg;
    localparam int CNT_W = 24;

    typedef enum logic [1:0] {
        SRC_4K  = 2'b00,
        SRC_64  = 2'b01,
        SRC_SEC = 2'b10,
        SRC_MIN = 2'b11
    } src_e;

    localparam logic [7:0] A_PRE_LO  = 8'h0B;
    localparam logic [7:0] A_PRE_MID = 8'h0C;
    localparam logic [7:0] A_MODE    = 8'h0D;
    localparam logic [7:0] A_FLAG    = 8'h0E;
    localparam logic [7:0] A_CTRL    = 8'h0F;
    localparam logic [7:0] A_MON_LO  = 8'h1C;
    localparam logic [7:0] A_MON_MID = 8'h1D;
    localparam logic [7:0] A_MON_HI  = 8'h1E;
    localparam logic [7:0] A_PRE_HI  = 8'h1F;

    typedef struct packed {
        logic [CNT_W-1:0] preset;
        src_e             sel;
        logic             run_en;
        logic             irq_en;
        logic             hold;
        logic             flag;
    } regs_t;
endpackage

// File: rtl/ct_tick_sel.sv
`timescale 1ns/1ps
module ct_tick_sel
    import ct_pkg::*;
(
    input  src_e sel,
    input  logic tick_4k,
    input  logic tick_64,
    input  logic tick_sec,
    input  logic tick_min,
    output logic src_tick,
    output logic fast_src
);
    always_comb begin
        unique case (sel)
            SRC_4K:  src_tick = tick_4k;
            SRC_64:  src_tick = tick_64;
            SRC_SEC: src_tick = tick_sec;
            default: src_tick = tick_min;
        endcase
        fast_src = (sel == SRC_4K);
    end
endmodule

// File: rtl/ct_down.sv
`timescale 1ns/1ps
module ct_down #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] preset,
    output logic [W-1:0] count,
    output logic         evt
);
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         loaded;
    } dn_t;

    dn_t st_d, st_q;
    logic evt_d;

    always_comb begin
        st_d  = st_q;
        evt_d = 1'b0;
        if (restart) begin
            st_d.loaded = 1'b0;
        end else if (run && tick) begin
            if (!st_q.loaded) begin
                st_d.cnt    = preset;
                st_d.loaded = 1'b1;
            end else if (st_q.cnt <= ONE) begin
                st_d.cnt = preset;
                evt_d    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign evt   = evt_d;
endmodule

// File: rtl/ct_pulse.sv
`timescale 1ns/1ps
module ct_pulse #(
    parameter int LONG_TICKS  = 32,
    parameter int SHORT_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic short_sel,
    input  logic tick_4k,
    input  logic release_now,
    output logic irq_n
);
    localparam int PW_W = $clog2(LONG_TICKS + 1);
    localparam logic [PW_W-1:0] ONE = PW_W'(1);

    typedef struct packed {
        logic [PW_W-1:0] left;
        logic            low;
    } pl_t;

    pl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.low  = 1'b1;
            st_d.left = short_sel ? PW_W'(SHORT_TICKS) : PW_W'(LONG_TICKS);
        end else if (release_now) begin
            st_d.low  = 1'b0;
            st_d.left = '0;
        end else if (st_q.low && tick_4k) begin
            if (st_q.left <= ONE) begin
                st_d.low  = 1'b0;
                st_d.left = '0;
            end else begin
                st_d.left = st_q.left - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n = ~st_q.low;
endmodule

// File: rtl/cyc_timer.sv
`timescale 1ns/1ps
module cyc_timer
    import ct_pkg::*;
#(
    parameter int LONG_TICKS  = 32,
    parameter int SHORT_TICKS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_4k,
    input  logic       tick_64,
    input  logic       tick_sec,
    input  logic       tick_min,
    input  logic [7:0] reg_addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       irq_n
);
    regs_t r_d, r_q;

    logic             wr_mode, wr_flag, wr_ctrl;
    logic             src_tick, fast_src;
    logic             restart, run, evt, release_now;
    logic [CNT_W-1:0] count;

    assign wr_mode = wr_en && (reg_addr == A_MODE);
    assign wr_flag = wr_en && (reg_addr == A_FLAG);
    assign wr_ctrl = wr_en && (reg_addr == A_CTRL);

    assign restart     = wr_mode && wr_data[4] && !r_q.run_en;
    assign run         = r_q.run_en && !r_q.hold && (r_q.preset != '0);
    assign release_now = (wr_flag && !wr_data[4]) || (wr_ctrl && !wr_data[4]) || !r_q.irq_en;

    ct_tick_sel u_sel (
        .sel      (r_q.sel),
        .tick_4k  (tick_4k),
        .tick_64  (tick_64),
        .tick_sec (tick_sec),
        .tick_min (tick_min),
        .src_tick (src_tick),
        .fast_src (fast_src)
    );

    ct_down #(.W(CNT_W)) u_down (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (run),
        .tick    (src_tick),
        .preset  (r_q.preset),
        .count   (count),
        .evt     (evt)
    );

    ct_pulse #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_pulse (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (evt && r_q.irq_en),
        .short_sel   (fast_src),
        .tick_4k     (tick_4k),
        .release_now (release_now),
        .irq_n       (irq_n)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (reg_addr)
                A_PRE_LO:  r_d.preset[7:0]   = wr_data;
                A_PRE_MID: r_d.preset[15:8]  = wr_data;
                A_PRE_HI:  r_d.preset[23:16] = wr_data;
                A_MODE: begin
                    r_d.sel    = src_e'(wr_data[1:0]);
                    r_d.run_en = wr_data[4];
                end
                A_CTRL: begin
                    r_d.irq_en = wr_data[4];
                    r_d.hold   = wr_data[0];
                end
                default: ;
            endcase
        end
        if (wr_flag && !wr_data[4]) begin
            r_d.flag = 1'b0;
        end
        if (evt) begin
            r_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.sel    <= SRC_64;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_PRE_LO:  rd_data = r_q.preset[7:0];
            A_PRE_MID: rd_data = r_q.preset[15:8];
            A_PRE_HI:  rd_data = r_q.preset[23:16];
            A_MODE:    rd_data = {3'b000, r_q.run_en, 2'b00, r_q.sel};
            A_FLAG:    rd_data = {3'b000, r_q.flag, 4'b0000};
            A_CTRL:    rd_data = {3'b000, r_q.irq_en, 3'b000, r_q.hold};
            A_MON_LO:  rd_data = count[7:0];
            A_MON_MID: rd_data = count[15:8];
            A_MON_HI:  rd_data = count[23:16];
            default:   rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/ct_checker.sv
`timescale 1ns/1ps
module ct_checker #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         irq_n,
    input logic         evt,
    input logic         flag,
    input logic         irq_en,
    input logic         hold,
    input logic         clr_write,
    input logic [W-1:0] preset,
    input logic [W-1:0] count
);
    assert_reload_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (count != '0) && flag);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_write) |=> flag);

    assert_pin_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> irq_en);

    assert_event_drives_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && irq_en) |=> !irq_n);

    assert_zero_preset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (preset == '0) |-> !evt);

    assert_hold_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(count));
endmodule

bind cyc_timer ct_checker #(.W(ct_pkg::CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_n     (irq_n),
    .evt       (evt),
    .flag      (r_q.flag),
    .irq_en    (r_q.irq_en),
    .hold      (r_q.hold),
    .clr_write (wr_flag && !wr_data[4]),
    .preset    (r_q.preset),
    .count     (count)
);

// File: tb/cyc_timer_test.sv
`timescale 1ns/1ps
module cyc_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ticks = 4'b0000;
    logic [7:0] reg_addr = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_n;
    logic       rd_strobe = 1'b0;
    logic       done = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [8:0] expq[$];
    string      tagq[$];
    logic [8:0] cur;
    string      curtag;
    logic [7:0] act;

    always #2.5 clk = ~clk;

    cyc_timer uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_4k  (ticks[0]),
        .tick_64  (ticks[1]),
        .tick_sec (ticks[2]),
        .tick_min (ticks[3]),
        .reg_addr (reg_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .irq_n    (irq_n)
    );

    // monitor: compare queued expectations after the edge settles
    always @(posedge clk) begin
        #2;
        if (rd_strobe && expq.size() > 0) begin
            cur    = expq.pop_front();
            curtag = tagq.pop_front();
            act    = cur[8] ? {7'b0, irq_n} : rd_data;
            checks++;
            if (act !== cur[7:0]) begin
                errors++;
                $display("FAIL %s actual %h expected %h", curtag, act, cur[7:0]);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tk(input int src, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ticks[src] = 1'b1;
            @(negedge clk);
            ticks[src] = 1'b0;
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        reg_addr = a;
        expq.push_back({1'b0, e});
        tagq.push_back(tag);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic pin(input logic e, input string tag);
        @(negedge clk);
        expq.push_back({1'b1, 7'b0, e});
        tagq.push_back(tag);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h0D, 8'h01, "R1 mode");
        rd(8'h0E, 8'h00, "R1 flag");
        rd(8'h1C, 8'h00, "R1 monitor");
        pin(1'b1, "R1 pin");
        // R2 storage
        wr(8'h0B, 8'h03); wr(8'h0C, 8'h00); wr(8'h1F, 8'hA5);
        rd(8'h0B, 8'h03, "R2 low");
        rd(8'h1F, 8'hA5, "R2 high");
        wr(8'h1F, 8'h00);
        // R3 load then count, 4096 Hz source
        wr(8'h0D, 8'h10);
        rd(8'h1C, 8'h00, "R3 before first tick");
        tk(0, 1); rd(8'h1C, 8'h03, "R3 load");
        tk(0, 1); rd(8'h1C, 8'h02, "R3 decrement");
        tk(1, 2); rd(8'h1C, 8'h02, "R5 unselected ignored");
        tk(0, 1); rd(8'h1C, 8'h01, "R3 one");
        tk(0, 1); rd(8'h1C, 8'h03, "R4 reload");
        rd(8'h0E, 8'h10, "R4 flag set");
        rd(8'h1D, 8'h00, "R4 mid");
        pin(1'b1, "R7 no irq disabled");
        // R6 flag semantics
        wr(8'h0E, 8'h10); rd(8'h0E, 8'h10, "R6 write one");
        wr(8'h0E, 8'h00); rd(8'h0E, 8'h00, "R6 write zero");
        // R7/R8 short pulse
        wr(8'h0F, 8'h10);
        tk(0, 2); pin(1'b1, "R7 before event");
        tk(0, 1); pin(1'b0, "R7 event low");
        tk(0, 1); pin(1'b1, "R8 short release");
        rd(8'h0E, 8'h10, "R6 not auto cleared");
        rd(8'h1C, 8'h02, "R3 counting on");
        // R10 run off holds
        wr(8'h0D, 8'h00);
        tk(0, 3); rd(8'h1C, 8'h02, "R10 run off holds");
        // R3 restart, 64 Hz, R8 long pulse
        wr(8'h0E, 8'h00);
        wr(8'h0D, 8'h11);
        tk(1, 1); rd(8'h1C, 8'h03, "R3 restart reload");
        tk(1, 2); tk(1, 1); pin(1'b0, "R8 long start");
        tk(0, 31); pin(1'b0, "R8 long held");
        tk(0, 1); pin(1'b1, "R8 long release");
        // R9 zero preset
        wr(8'h0E, 8'h00); wr(8'h0B, 8'h00);
        tk(1, 4);
        rd(8'h1C, 8'h03, "R9 count holds");
        rd(8'h0E, 8'h00, "R9 no event");
        pin(1'b1, "R9 pin");
        // R10 hold bit
        wr(8'h0B, 8'h03); wr(8'h0F, 8'h11);
        tk(1, 2); rd(8'h1C, 8'h03, "R10 hold");
        rd(8'h0F, 8'h11, "R10 ctrl readback");
        // R11 release by writes
        wr(8'h0F, 8'h10);
        tk(1, 3); pin(1'b0, "R11 low before clear");
        wr(8'h0E, 8'h00); pin(1'b1, "R11 flag clear releases");
        rd(8'h0E, 8'h00, "R11 flag cleared");
        tk(1, 3); pin(1'b0, "R11 low again");
        wr(8'h0F, 8'h00); pin(1'b1, "R11 enable clear releases");
        // R2 monitor read-only
        wr(8'h1C, 8'h55); rd(8'h1C, 8'h03, "R2 monitor write ignored");
        // R5 second and minute sources
        wr(8'h0E, 8'h00);
        wr(8'h0D, 8'h02); wr(8'h0B, 8'h02); wr(8'h0D, 8'h12);
        tk(3, 2); rd(8'h1C, 8'h03, "R5 minute ignored on second");
        tk(2, 1); rd(8'h1C, 8'h02, "R5 second load");
        tk(2, 1); rd(8'h1C, 8'h01, "R5 second decrement");
        wr(8'h0D, 8'h13);
        tk(2, 1); rd(8'h1C, 8'h01, "R5 second ignored on minute");
        tk(3, 1); rd(8'h1C, 8'h02, "R5 minute reload");
        rd(8'h0E, 8'h10, "R5 minute event flag");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule